// File: doc/BRIEF.md
# In-Order-Retire Scoreboard and Reorder Buffer

This block follows every instruction from the moment it is issued until it retires. It keeps them in one circular buffer. Each slot holds the destination register, the result, an exception flag with its cause, and a small per-slot state machine. The issue logic allocates slots in program order and gets the slot index back as a tag. Functional units return results through several writeback ports, tagged with that index and in any order. Only the oldest slot is ever offered for retirement.

For each of its two source registers, the issue logic sees three things: whether a pending producer blocks it, whether a finished but not yet retired producer can forward its value, or neither, in which case the register file supplies the operand. Every slot is speculative until it retires. A global flush, or the retirement of a slot that carries an exception, empties the buffer in one cycle. Both pointers then restart at slot 0.

Each slot runs its own state machine with three states:
- ENT_FREE: the slot is empty.
- ENT_WAIT: the instruction is issued and waits for its result.
- ENT_DONE: the result is back and waits to retire.

Transitions: allocate (FREE to WAIT), writeback (WAIT to DONE), retire (DONE to FREE), and clear (any state to FREE, on flush or exception retirement).

Top module: `rob_scoreboard`

## Requirements
- R1: An issue is accepted when `issue_valid_i` and `issue_ready_o` are both high. The accepted instruction takes slot `issue_tag_o`. After reset or any clear, tags are handed out as 0, 1, 2, … and wrap modulo DEPTH (default 8).
- R2: While DEPTH slots are occupied, `issue_ready_o` is low and no instruction is accepted.
- R3: A source register is busy when its youngest occupied producer is still waiting for its result. A producer is a slot whose destination equals the source and is nonzero. While either source is busy, `issue_ready_o` is low. Register 0 is never busy.
- R4: When the youngest producer of a source has its result, `rsN_fwd_o` is 1 and `rsN_data_o` equals that result. With no occupied producer, both `rsN_busy_o` and `rsN_fwd_o` are 0.
- R5: Writeback port p, with `wb_valid_i[p]` high, writes to the slot named by `wb_tag_i[p*IDX_W +: IDX_W]`. It stores `wb_data_i[p*XLEN +: XLEN]`, the exception flag `wb_exc_i[p]` and the cause `wb_cause_i[p*CW +: CW]`, and moves the slot to done. A port may only target a slot that is waiting. Ports may complete slots in any order.
- R6: `flush_i` empties the buffer by the next cycle, and the next tag is 0. An issue in the flush cycle is dropped.
- R7: `commit_valid_o` is high exactly when the oldest slot is done. The outputs then show that slot's destination and result. `commit_ack_i` retires it. A younger slot that is done is never shown first.
- R8: `commit_we_o` is high only when `commit_valid_o` is high, the slot has no exception, and its destination is nonzero.
- R9: When the oldest done slot has an exception, `commit_exc_o` is high and `commit_cause_o` shows its cause. Acknowledging it discards every younger slot and any issue in the same cycle, and the next tag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Discard all slots |
| issue_valid_i | input | 1 | Issue request |
| issue_rd_i | input | RW | Destination register of the request |
| issue_rs1_i | input | RW | First source register |
| issue_rs2_i | input | RW | Second source register |
| issue_ready_o | output | 1 | Request can be accepted |
| issue_tag_o | output | IDX_W | Slot the request will occupy |
| rs1_busy_o | output | 1 | First source waits on a pending producer |
| rs1_fwd_o | output | 1 | First source forwarded from the buffer |
| rs1_data_o | output | XLEN | Forwarded value for the first source |
| rs2_busy_o | output | 1 | Second source waits on a pending producer |
| rs2_fwd_o | output | 1 | Second source forwarded from the buffer |
| rs2_data_o | output | XLEN | Forwarded value for the second source |
| wb_valid_i | input | NR_WB | Per-port writeback strobe |
| wb_tag_i | input | NR_WB*IDX_W | Per-port target slot |
| wb_data_i | input | NR_WB*XLEN | Per-port result |
| wb_exc_i | input | NR_WB | Per-port exception flag |
| wb_cause_i | input | NR_WB*CW | Per-port exception cause |
| commit_valid_o | output | 1 | Oldest slot is ready to retire |
| commit_ack_i | input | 1 | Retire the oldest slot |
| commit_rd_o | output | RW | Destination of the oldest slot |
| commit_data_o | output | XLEN | Result of the oldest slot |
| commit_we_o | output | 1 | Register file write enable |
| commit_exc_o | output | 1 | Oldest slot carries an exception |
| commit_cause_o | output | CW | Exception cause of the oldest slot |

## Verification
The hardest case to reach is an exception on a slot in the middle of the buffer. At the time it retires, younger slots have already finished out of order and a new issue arrives in the same cycle. A directed sequence builds exactly that: three issues, two writebacks in one cycle with the exception on the later port, a third writeback, then acknowledges with an issue held high.

A bench reference model tracks every slot so that busy and forwarding answers can be checked against the youngest producer. Random phases switch between slow and fast acknowledgement, so that both the full buffer and the empty buffer are reached many times.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_WAIT = 2'd1,
        ENT_DONE = 2'd2
    } ent_state_e;
endpackage

// File: rtl/rob_ptrs.sv
// Head/tail pointers and occupancy; DEPTH must be a power of two so that
// the pointers wrap by natural overflow.
module rob_ptrs #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             alloc_i,
    input  logic             retire_i,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] tail_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o
);
    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (clr_i) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (alloc_i)  tail_q <= tail_q + 1'b1;
            if (retire_i) head_q <= head_q + 1'b1;
            count_q <= count_q + CNT_W'(alloc_i) - CNT_W'(retire_i);
        end
    end

    assign head_o  = head_q;
    assign tail_o  = tail_q;
    assign count_o = count_q;
    assign full_o  = (count_q == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_q <= CNT_W'(DEPTH)); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retire_i |-> count_q != '0); // R7
    AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (count_q == '0 && head_q == '0 && tail_q == '0)); // R6
endmodule

// File: rtl/rob_entry.sv
module rob_entry
    import rob_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RW   = 5,
    parameter int CW   = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            clr_i,
    input  logic            alloc_i,
    input  logic [RW-1:0]   alloc_rd_i,
    input  logic            wb_hit_i,
    input  logic [XLEN-1:0] wb_data_i,
    input  logic            wb_exc_i,
    input  logic [CW-1:0]   wb_cause_i,
    input  logic            retire_i,
    output ent_state_e      state_o,
    output logic [RW-1:0]   rd_o,
    output logic [XLEN-1:0] data_o,
    output logic            exc_o,
    output logic [CW-1:0]   cause_o
);
    ent_state_e      state_q, state_d;
    logic [RW-1:0]   rd_q;
    logic [XLEN-1:0] data_q;
    logic            exc_q;
    logic [CW-1:0]   cause_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: if (alloc_i)  state_d = ENT_WAIT;
            ENT_WAIT: if (wb_hit_i) state_d = ENT_DONE;
            ENT_DONE: if (retire_i) state_d = ENT_FREE;
            default:                state_d = ENT_FREE;
        endcase
        if (clr_i) state_d = ENT_FREE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ENT_FREE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q    <= '0;
            data_q  <= '0;
            exc_q   <= 1'b0;
            cause_q <= '0;
        end else if (alloc_i && state_q == ENT_FREE) begin
            rd_q  <= alloc_rd_i;
            exc_q <= 1'b0;
        end else if (wb_hit_i && state_q == ENT_WAIT) begin
            data_q  <= wb_data_i;
            exc_q   <= wb_exc_i;
            cause_q <= wb_cause_i;
        end
    end

    assign state_o = state_q;
    assign rd_o    = rd_q;
    assign data_o  = data_q;
    assign exc_o   = exc_q;
    assign cause_o = cause_q;

    AST_ALLOC_INTO_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alloc_i |-> state_q == ENT_FREE); // R1
    AST_RETIRE_ONLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retire_i |-> state_q == ENT_DONE); // R7
endmodule

// File: rtl/rob_fwd.sv
// Finds the youngest occupied producer of one source register.
module rob_fwd
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    parameter int RW    = 5,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  ent_state_e      state_i [DEPTH],
    input  logic [RW-1:0]   rd_i    [DEPTH],
    input  logic [XLEN-1:0] data_i  [DEPTH],
    input  logic [IDX_W-1:0] head_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [RW-1:0]   rs_i,
    output logic            busy_o,
    output logic            fwd_o,
    output logic [XLEN-1:0] data_o
);
    always_comb begin
        logic             hit;
        logic             done;
        logic [IDX_W-1:0] idx;
        hit    = 1'b0;
        done   = 1'b0;
        data_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_i + IDX_W'(k);
            if (k < int'(count_i) && rs_i != '0 && rd_i[idx] == rs_i) begin
                hit    = 1'b1;
                done   = (state_i[idx] == ENT_DONE);
                data_o = data_i[idx];
            end
        end
        busy_o = hit && !done;
        fwd_o  = hit && done;
    end
endmodule

// File: rtl/rob_scoreboard.sv
module rob_scoreboard
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NR_WB = 2,
    parameter int XLEN  = 32,
    parameter int RW    = 5,
    parameter int CW    = 4,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   flush_i,
    input  logic                   issue_valid_i,
    input  logic [RW-1:0]          issue_rd_i,
    input  logic [RW-1:0]          issue_rs1_i,
    input  logic [RW-1:0]          issue_rs2_i,
    output logic                   issue_ready_o,
    output logic [IDX_W-1:0]       issue_tag_o,
    output logic                   rs1_busy_o,
    output logic                   rs1_fwd_o,
    output logic [XLEN-1:0]        rs1_data_o,
    output logic                   rs2_busy_o,
    output logic                   rs2_fwd_o,
    output logic [XLEN-1:0]        rs2_data_o,
    input  logic [NR_WB-1:0]       wb_valid_i,
    input  logic [NR_WB*IDX_W-1:0] wb_tag_i,
    input  logic [NR_WB*XLEN-1:0]  wb_data_i,
    input  logic [NR_WB-1:0]       wb_exc_i,
    input  logic [NR_WB*CW-1:0]    wb_cause_i,
    output logic                   commit_valid_o,
    input  logic                   commit_ack_i,
    output logic [RW-1:0]          commit_rd_o,
    output logic [XLEN-1:0]        commit_data_o,
    output logic                   commit_we_o,
    output logic                   commit_exc_o,
    output logic [CW-1:0]          commit_cause_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    ent_state_e      ent_state [DEPTH];
    logic [RW-1:0]   ent_rd    [DEPTH];
    logic [XLEN-1:0] ent_data  [DEPTH];
    logic            ent_exc   [DEPTH];
    logic [CW-1:0]   ent_cause [DEPTH];
    logic [DEPTH-1:0] live;

    logic [IDX_W-1:0] head, tail;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             commit_fire, exc_kill, clr, alloc;

    assign commit_fire = commit_valid_o && commit_ack_i;
    assign exc_kill    = commit_fire && commit_exc_o;
    assign clr         = flush_i || exc_kill;
    assign alloc       = issue_valid_i && issue_ready_o && !clr;

    rob_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_ptrs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (clr),
        .alloc_i  (alloc),
        .retire_i (commit_fire),
        .head_o   (head),
        .tail_o   (tail),
        .count_o  (count),
        .full_o   (full)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic            hit;
        logic [XLEN-1:0] hdata;
        logic            hexc;
        logic [CW-1:0]   hcause;

        always_comb begin
            hit    = 1'b0;
            hdata  = '0;
            hexc   = 1'b0;
            hcause = '0;
            for (int p = 0; p < NR_WB; p++) begin
                if (wb_valid_i[p] && wb_tag_i[p*IDX_W +: IDX_W] == IDX_W'(i)) begin
                    hit    = 1'b1;
                    hdata  = wb_data_i[p*XLEN +: XLEN];
                    hexc   = wb_exc_i[p];
                    hcause = wb_cause_i[p*CW +: CW];
                end
            end
        end

        rob_entry #(.XLEN(XLEN), .RW(RW), .CW(CW)) i_entry (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .clr_i      (clr),
            .alloc_i    (alloc && tail == IDX_W'(i)),
            .alloc_rd_i (issue_rd_i),
            .wb_hit_i   (hit),
            .wb_data_i  (hdata),
            .wb_exc_i   (hexc),
            .wb_cause_i (hcause),
            .retire_i   (commit_fire && head == IDX_W'(i)),
            .state_o    (ent_state[i]),
            .rd_o       (ent_rd[i]),
            .data_o     (ent_data[i]),
            .exc_o      (ent_exc[i]),
            .cause_o    (ent_cause[i])
        );

        assign live[i] = (ent_state[i] != ENT_FREE);
    end

    rob_fwd #(.DEPTH(DEPTH), .XLEN(XLEN), .RW(RW), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_fwd_rs1 (
        .state_i (ent_state),
        .rd_i    (ent_rd),
        .data_i  (ent_data),
        .head_i  (head),
        .count_i (count),
        .rs_i    (issue_rs1_i),
        .busy_o  (rs1_busy_o),
        .fwd_o   (rs1_fwd_o),
        .data_o  (rs1_data_o)
    );

    rob_fwd #(.DEPTH(DEPTH), .XLEN(XLEN), .RW(RW), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_fwd_rs2 (
        .state_i (ent_state),
        .rd_i    (ent_rd),
        .data_i  (ent_data),
        .head_i  (head),
        .count_i (count),
        .rs_i    (issue_rs2_i),
        .busy_o  (rs2_busy_o),
        .fwd_o   (rs2_fwd_o),
        .data_o  (rs2_data_o)
    );

    assign issue_ready_o  = !full && !rs1_busy_o && !rs2_busy_o;
    assign issue_tag_o    = tail;

    assign commit_valid_o = (ent_state[head] == ENT_DONE);
    assign commit_rd_o    = ent_rd[head];
    assign commit_data_o  = ent_data[head];
    assign commit_exc_o   = commit_valid_o && ent_exc[head];
    assign commit_cause_o = ent_cause[head];
    assign commit_we_o    = commit_valid_o && !ent_exc[head] && ent_rd[head] != '0;

    AST_LIVE_MATCHES_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(live) == int'(count)); // R2

    for (genvar p = 0; p < NR_WB; p++) begin : g_wb_chk
        AST_WB_TARGETS_WAITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wb_valid_i[p] |-> ent_state[wb_tag_i[p*IDX_W +: IDX_W]] == ENT_WAIT); // R5
    end
endmodule

// File: tb/test_rob_scoreboard.sv
`timescale 1ns/1ps
module test_rob_scoreboard;
    localparam int D  = 8;
    localparam int NW = 2;
    localparam int XL = 32;
    localparam int RW = 5;
    localparam int CW = 4;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, flush;
    logic iv;
    logic [RW-1:0] ird, irs1, irs2;
    logic ready;
    logic [IW-1:0] tag;
    logic b1, f1, b2, f2;
    logic [XL-1:0] d1, d2;
    logic wv [NW];
    logic [IW-1:0] wt [NW];
    logic [XL-1:0] wd [NW];
    logic we_x [NW];
    logic [CW-1:0] wc [NW];
    logic ack, cv, cwe, cexc;
    logic [RW-1:0] crd;
    logic [XL-1:0] cdata;
    logic [CW-1:0] ccause;

    rob_scoreboard #(.DEPTH(D), .NR_WB(NW), .XLEN(XL), .RW(RW), .CW(CW)) i_rob_scoreboard (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
        .issue_valid_i(iv), .issue_rd_i(ird), .issue_rs1_i(irs1), .issue_rs2_i(irs2),
        .issue_ready_o(ready), .issue_tag_o(tag),
        .rs1_busy_o(b1), .rs1_fwd_o(f1), .rs1_data_o(d1),
        .rs2_busy_o(b2), .rs2_fwd_o(f2), .rs2_data_o(d2),
        .wb_valid_i({wv[1], wv[0]}), .wb_tag_i({wt[1], wt[0]}),
        .wb_data_i({wd[1], wd[0]}), .wb_exc_i({we_x[1], we_x[0]}),
        .wb_cause_i({wc[1], wc[0]}),
        .commit_valid_o(cv), .commit_ack_i(ack), .commit_rd_o(crd),
        .commit_data_o(cdata), .commit_we_o(cwe), .commit_exc_o(cexc),
        .commit_cause_o(ccause)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    bit            m_live [D];
    bit            m_done [D];
    bit            m_exc  [D];
    logic [RW-1:0] m_rd   [D];
    logic [XL-1:0] m_data [D];
    logic [CW-1:0] m_cause[D];
    int m_head, m_tail, m_cnt;
    bit e_ready, e_cv, last_flush, last_kill;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < D; i++) begin
            m_live[i] = 0; m_done[i] = 0; m_exc[i] = 0;
        end
        m_head = 0; m_tail = 0; m_cnt = 0;
    endfunction

    function automatic void src_lookup(input logic [RW-1:0] rs, output bit b,
                                       output bit f, output logic [XL-1:0] d);
        b = 0; f = 0; d = '0;
        for (int k = 0; k < m_cnt; k++) begin
            int idx;
            idx = (m_head + k) % D;
            if (rs != 0 && m_rd[idx] == rs) begin
                b = !m_done[idx]; f = m_done[idx]; d = m_data[idx];
            end
        end
    endfunction

    task automatic check_outputs();
        bit eb1, ef1, eb2, ef2;
        logic [XL-1:0] ed1, ed2;
        string tag_req;
        src_lookup(irs1, eb1, ef1, ed1);
        src_lookup(irs2, eb2, ef2, ed2);
        e_ready = (m_cnt < D) && !eb1 && !eb2;
        e_cv    = (m_cnt > 0) && m_done[m_head];
        tag_req = last_kill ? "R9 tag restart" : (last_flush ? "R6 tag restart" : "R1 tag");
        check(m_cnt == D ? "R2 ready when full" : "R3 ready", 64'(ready), 64'(e_ready));
        check(tag_req, 64'(tag), 64'(m_tail));
        check("R3 rs1 busy", 64'(b1), 64'(eb1));
        check("R4 rs1 fwd", 64'(f1), 64'(ef1));
        if (ef1) check("R4 rs1 data", 64'(d1), 64'(ed1));
        check("R3 rs2 busy", 64'(b2), 64'(eb2));
        check("R4 rs2 fwd", 64'(f2), 64'(ef2));
        if (ef2) check("R4 rs2 data", 64'(d2), 64'(ed2));
        check("R7 commit valid", 64'(cv), 64'(e_cv));
        if (e_cv) begin
            check("R7 commit rd", 64'(crd), 64'(m_rd[m_head]));
            check("R5 commit data", 64'(cdata), 64'(m_data[m_head]));
            check("R8 write enable", 64'(cwe), 64'(!m_exc[m_head] && m_rd[m_head] != 0));
            check("R9 exception", 64'(cexc), 64'(m_exc[m_head]));
            if (m_exc[m_head]) check("R9 cause", 64'(ccause), 64'(m_cause[m_head]));
        end else begin
            check("R8 no write", 64'(cwe), 64'd0);
        end
    endtask

    task automatic model_update();
        bit fire, kill;
        fire = e_cv && ack;
        kill = fire && m_exc[m_head];
        for (int p = 0; p < NW; p++) begin
            if (wv[p]) begin
                m_done[wt[p]] = 1; m_data[wt[p]] = wd[p];
                m_exc[wt[p]] = we_x[p]; m_cause[wt[p]] = wc[p];
            end
        end
        last_flush = flush;
        last_kill  = kill;
        if (flush || kill) begin
            model_clear();
        end else begin
            if (fire) begin
                m_live[m_head] = 0; m_done[m_head] = 0;
                m_head = (m_head + 1) % D; m_cnt--;
            end
            if (iv && e_ready) begin
                m_live[m_tail] = 1; m_done[m_tail] = 0; m_exc[m_tail] = 0;
                m_rd[m_tail] = ird;
                m_tail = (m_tail + 1) % D; m_cnt++;
            end
        end
    endtask

    task automatic cycle();
        #1 check_outputs();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic no_wb();
        for (int p = 0; p < NW; p++) begin
            wv[p] = 0; wt[p] = '0; wd[p] = '0; we_x[p] = 0; wc[p] = '0;
        end
    endtask

    task automatic set_wb(input int p, input int t, input logic [XL-1:0] d,
                          input bit e, input logic [CW-1:0] c);
        wv[p] = 1; wt[p] = IW'(t); wd[p] = d; we_x[p] = e; wc[p] = c;
    endtask

    task automatic set_issue(input bit v, input int rd, input int r1, input int r2);
        iv = v; ird = RW'(rd); irs1 = RW'(r1); irs2 = RW'(r2);
    endtask

    task automatic rand_wb();
        int cand[D];
        int nc;
        nc = 0;
        for (int i = 0; i < D; i++) if (m_live[i] && !m_done[i]) begin cand[nc] = i; nc++; end
        no_wb();
        for (int p = 0; p < NW; p++) begin
            if (nc > 0 && ($urandom % 2) == 0) begin
                int j;
                j = int'($urandom % nc);
                set_wb(p, cand[j], $urandom, ($urandom % 12) == 0, CW'($urandom));
                cand[j] = cand[nc-1]; nc--;
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        finish_run();
    end

    initial begin
        int t0;
        void'($urandom(32'd20240611));
        rst_n = 0; flush = 0; ack = 0;
        set_issue(0, 0, 0, 0); no_wb();
        last_flush = 0; last_kill = 0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // reset state (R1, R7): tag 0, nothing to commit
        cycle();

        // R2: fill all slots, then try one more
        for (int i = 0; i < D; i++) begin
            set_issue(1, i + 1, 0, 0);
            cycle();
        end
        set_issue(1, 9, 0, 0);
        cycle();
        // R5, R7: out-of-order writeback of slots 5 and 2, head still waiting
        set_issue(0, 0, 0, 0);
        set_wb(0, 5, 32'h5555_0005, 0, 0);
        set_wb(1, 2, 32'h2222_0002, 0, 0);
        cycle();
        no_wb();
        ack = 1;
        // R3/R4: rs1=3 forwards from done slot 2, rs2=4 waits on slot 3
        set_issue(1, 1, 3, 4);
        cycle();
        cycle();
        set_issue(0, 0, 0, 0);
        set_wb(0, 0, 32'hAAAA_0000, 0, 0);
        set_wb(1, 1, 32'hBBBB_0001, 0, 0);
        cycle();
        no_wb();
        repeat (4) cycle();
        // R6: flush with a concurrent issue
        flush = 1;
        set_issue(1, 7, 0, 0);
        cycle();
        flush = 0;
        set_issue(0, 0, 0, 0);
        cycle();

        // R8: destination zero never writes
        set_issue(1, 0, 0, 0);
        cycle();
        set_issue(0, 0, 0, 0);
        set_wb(0, 0, 32'hDEAD_BEEF, 0, 0);
        cycle();
        no_wb();
        ack = 1;
        cycle();
        ack = 0;
        cycle();

        // R9: exception on the middle slot, younger slots done, issue in kill cycle
        t0 = m_tail;
        for (int i = 0; i < 3; i++) begin
            set_issue(1, i + 1, 0, 0);
            cycle();
        end
        set_issue(0, 0, 0, 0);
        set_wb(0, t0, 32'h0000_1111, 0, 0);
        set_wb(1, (t0 + 1) % D, 32'h0000_2222, 1, 4'd5);
        cycle();
        no_wb();
        set_wb(0, (t0 + 2) % D, 32'h0000_3333, 0, 0);
        cycle();
        no_wb();
        ack = 1;
        set_issue(1, 6, 0, 0);
        repeat (3) cycle();
        ack = 0;
        set_issue(0, 0, 0, 0);
        cycle();

        // random phases with varying acknowledge rate
        for (int ph = 0; ph < 8; ph++) begin
            int ack_pct;
            ack_pct = (ph % 2 == 0) ? 20 : 80;
            for (int c = 0; c < 500; c++) begin
                set_issue(($urandom % 10) < 7, int'($urandom % 8),
                          ($urandom % 3 == 0) ? 0 : int'($urandom % 8),
                          ($urandom % 3 == 0) ? 0 : int'($urandom % 8));
                rand_wb();
                ack   = int'($urandom % 100) < ack_pct;
                flush = ($urandom % 97) == 0;
                cycle();
            end
        end
        flush = 0; ack = 0; set_issue(0, 0, 0, 0); no_wb();
        cycle();
        finish_run();
    end
endmodule